// File: doc/BRIEF.md
# Processor Tick Timer

This block is the tick timer of a processor core. A 32-bit count register advances once for each pulse on a tick-enable input, which the chip asserts for one clock cycle every 50 ns (a 20 MHz tick). A 32-bit control register holds a period compare value, an interrupt enable, a sticky interrupt pending flag and a two-bit mode. The compare looks only at the low period bits of the count. When those bits reach the compare value, the timer can flag an interrupt, and then it clears the count, stops, or keeps running, as the mode selects.

Software reads and writes both registers through a single-cycle register port. Address 0 selects the count and address 1 the control register. Read data is registered. The interrupt request goes to the core's interrupt logic.

Top module: `tick_timer`

## Requirements
- R1: The count increases by exactly one on each clock cycle in which `tick_en` is high and counting is active. Counting is active when the mode is nonzero and the timer is not stopped by a one-shot match. Cycles with `tick_en` low leave the count unchanged.
- R2: A match happens on a counting tick when bits 27:0 of the incremented count equal the period field (control bits 27:0). Count bits 31:28 take no part in the compare.
- R3: When the low 28 count bits are already past the period value, no match occurs until those bits wrap through zero and reach the period value again.
- R4: A match while interrupt enable (control bit 29) is 1 sets the pending bit (control bit 28). `irq_o` is a registered output equal to pending AND enable, and it changes on the same clock edge as those bits.
- R5: In restart mode (control bits 31:30 = 01), a match clears all 32 count bits to zero.
- R6: In one-shot mode (10), a match loads the matching value into the count and stops counting. The count then holds through later ticks.
- R7: In continuous mode (11), a match leaves the count running. In disabled mode (00), the count does not move, no match occurs and the pending bit is unchanged.
- R8: Reset (synchronous, active high) clears the count, the control register, `irq_o` and `reg_rdata` to zero.
- R9: A write to address 0 loads the count on that clock edge. The write takes priority over a tick in the same cycle, and later ticks count up from the written value.
- R10: A write to address 1 loads all 32 control bits, including the pending bit, so that software clears pending by writing 0 to it. A match with enable set in the same cycle still sets pending. Outside a write or a match, pending keeps its value.
- R11: Writing the control register clears a one-shot stop. With a nonzero mode, counting then resumes from the held count.
- R12: `reg_rdata` shows, one clock edge after `reg_addr` is applied, the register that address selects. It does not change between clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle 20 MHz tick pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 count, 1 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| irq_o | output | 1 | Registered timer interrupt request |

## Verification
The assertions assume that `tick_en` is a clean synchronous pulse. They also assume that a write strobe is sampled as a full-cycle event, which lets a write legitimately override a tick or a match in the same cycle. The properties therefore hold the count stable only when no write is present. The stimulus changes inputs only on the falling edge, keeps writes and ticks apart except in the one directed case that tests their overlap, and holds `tick_en` low while it reads back registers, so every read sees a settled state.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    TT_OFF     = 2'b00,
    TT_RESTART = 2'b01,
    TT_ONESHOT = 2'b10,
    TT_CONT    = 2'b11
  } tt_mode_e;
endpackage

// File: rtl/tt_match.sv
module tt_match #(
  parameter int CNT_W = 32,
  parameter int PER_W = CNT_W - 4
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  output logic [CNT_W-1:0] nxt_o,
  output logic             hit_o
);
  logic eq;

  assign nxt_o = cnt_i + {{(CNT_W-1){1'b0}}, 1'b1};

  generate
    if (PER_W >= CNT_W) begin : g_full
      assign eq = (nxt_o == period_i[CNT_W-1:0]);
    end else begin : g_low
      assign eq = (nxt_o[PER_W-1:0] == period_i);
    end
  endgenerate

  // a write to the count wins over the tick, so it also suppresses the match
  assign hit_o = tick_i & run_i & ~cnt_wr_i & eq;
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             mode_wr_i,
  input  tt_mode_e         mode_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             halted_q;

  assign run_o = (mode_i != TT_OFF) & ~halted_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
    end else if (mode_wr_i) begin
      halted_q <= 1'b0;
    end else if (hit_i && mode_i == TT_ONESHOT) begin
      halted_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_wr_i) begin
      cnt_q <= wdata_i;
    end else if (hit_i && mode_i == TT_RESTART) begin
      cnt_q <= '0;
    end else if (tick_i && run_o) begin
      cnt_q <= nxt_i;
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr_i && !(tick_i && run_o)) |=> $stable(cnt_q));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i && mode_i == TT_RESTART) |=> (cnt_q == '0));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halted_q && !cnt_wr_i && !mode_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tt_mode_reg.sv
module tt_mode_reg
  import tt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = CNT_W - 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             hit_i,
  output tt_mode_e         mode_o,
  output logic             ie_o,
  output logic             pend_o,
  output logic [PER_W-1:0] period_o,
  output logic             irq_o
);
  localparam int PEND_B = PER_W;
  localparam int IE_B   = PER_W + 1;
  localparam int MODE_L = PER_W + 2;

  tt_mode_e         mode_q;
  logic             ie_q, pend_q, irq_q;
  logic [PER_W-1:0] period_q;
  logic             ie_d, pend_d;

  always_comb begin
    ie_d   = wr_i ? wdata_i[IE_B] : ie_q;
    pend_d = (wr_i ? wdata_i[PEND_B] : pend_q) | (hit_i & ie_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= TT_OFF;
      ie_q     <= 1'b0;
      pend_q   <= 1'b0;
      period_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_i) begin
        mode_q   <= tt_mode_e'(wdata_i[MODE_L +: 2]);
        period_q <= wdata_i[PER_W-1:0];
      end
      ie_q   <= ie_d;
      pend_q <= pend_d;
      irq_q  <= pend_d & ie_d;
    end
  end

  assign mode_o   = mode_q;
  assign ie_o     = ie_q;
  assign pend_o   = pend_q;
  assign period_o = period_q;
  assign irq_o    = irq_q;

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i && ie_q) |=> pend_q);

  // R10
  pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !hit_i) |=> $stable(pend_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq_o
);
  localparam int PER_W = CNT_W - 4;

  logic             cnt_wr, mode_wr, hit, run;
  logic [CNT_W-1:0] cnt, nxt, rdata_q;
  tt_mode_e         mode;
  logic             ie, pend;
  logic [PER_W-1:0] period;

  assign cnt_wr  = reg_wr & ~reg_addr;
  assign mode_wr = reg_wr &  reg_addr;

  tt_match #(.CNT_W(CNT_W), .PER_W(PER_W)) u_match (
    .cnt_i(cnt), .period_i(period), .run_i(run), .tick_i(tick_en),
    .cnt_wr_i(cnt_wr), .nxt_o(nxt), .hit_o(hit)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_en), .cnt_wr_i(cnt_wr),
    .wdata_i(reg_wdata), .mode_wr_i(mode_wr), .mode_i(mode),
    .hit_i(hit), .nxt_i(nxt), .cnt_o(cnt), .run_o(run)
  );

  tt_mode_reg #(.CNT_W(CNT_W), .PER_W(PER_W)) u_mode (
    .clk(clk), .rst(rst), .wr_i(mode_wr), .wdata_i(reg_wdata),
    .hit_i(hit), .mode_o(mode), .ie_o(ie), .pend_o(pend),
    .period_o(period), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= reg_addr ? {mode, ie, pend, period} : cnt;
  end
  assign reg_rdata = rdata_q;

  // R7
  off_nohit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == TT_OFF) |-> !hit);

  // R4
  irq_en_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ie && pend));
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst = 1'b1, tick_en = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] mode_w;
    logic [31:0] cnt_w;
    logic [7:0]  nt;
    logic [31:0] exp_cnt;
    logic        exp_pend;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{32'h6000_0005, 32'h0000_0000, 8'd8,  32'h0000_0003, 1'b1, 4'd5}, // R5 restart then count on
    '{32'hA000_0004, 32'h0000_0000, 8'd10, 32'h0000_0004, 1'b1, 4'd6}, // R6 one-shot holds
    '{32'hC000_0003, 32'h0000_0000, 8'd6,  32'h0000_0006, 1'b0, 4'd7}, // R7 continuous, enable off
    '{32'h2000_0003, 32'h0000_0007, 8'd10, 32'h0000_0007, 1'b0, 4'd7}, // R7 disabled mode
    '{32'hE000_0002, 32'h1000_0000, 8'd2,  32'h1000_0002, 1'b1, 4'd2}, // R2 upper bits ignored
    '{32'hE000_0001, 32'h0FFF_FFFE, 8'd2,  32'h1000_0000, 1'b0, 4'd3}, // R3 no match before wrap
    '{32'hE000_0001, 32'h0FFF_FFFE, 8'd3,  32'h1000_0001, 1'b1, 4'd3}, // R3 match after wrap
    '{32'h6000_0003, 32'h8000_0001, 8'd2,  32'h0000_0000, 1'b1, 4'd5}, // R5 all 32 bits cleared
    '{32'hEFFF_FFFF, 32'h0FFF_FFFD, 8'd2,  32'h0FFF_FFFF, 1'b1, 4'd4}  // R4 top period value
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    chk(8, {31'd0, irq_o}, 32'd0, "irq after reset");
    rd(1'b0, v); chk(8, v, 32'd0, "count after reset");
    rd(1'b1, v); chk(8, v, 32'd0, "control after reset");

    for (int i = 0; i < 9; i++) begin
      wr(1'b0, VEC[i].cnt_w);
      wr(1'b1, VEC[i].mode_w);
      ticks(int'(VEC[i].nt));
      chk(int'(VEC[i].req), {31'd0, irq_o}, {31'd0, VEC[i].exp_pend & VEC[i].mode_w[29]}, "irq (R4)");
      rd(1'b0, v); chk(int'(VEC[i].req), v, VEC[i].exp_cnt, "count");
      rd(1'b1, v); chk(int'(VEC[i].req), v, VEC[i].mode_w | {3'd0, VEC[i].exp_pend, 28'd0}, "control (R10)");
    end

    // R12 read data registered: unchanged before the next edge
    @(negedge clk); reg_addr = 1'b0; #1;
    chk(12, reg_rdata, 32'hEFFF_FFFF | 32'h1000_0000, "rdata before edge");

    // R1 ticks with idle gaps
    wr(1'b1, 32'hC000_0100);
    wr(1'b0, 32'd0);
    for (int k = 0; k < 3; k++) begin
      ticks(1);
      @(negedge clk); @(negedge clk);
    end
    rd(1'b0, v); chk(1, v, 32'd3, "count with gapped ticks");

    // R9 write coincident with tick
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h50; tick_en = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    rd(1'b0, v); chk(9, v, 32'h50, "write beats tick");
    ticks(1);
    rd(1'b0, v); chk(9, v, 32'h51, "tick after write");

    // R6 / R11 one-shot hold then resume
    wr(1'b0, 32'd0);
    wr(1'b1, 32'hA000_0004);
    ticks(10);
    ticks(5);
    rd(1'b0, v); chk(6, v, 32'd4, "one-shot holds");
    wr(1'b1, 32'hA000_0004);
    ticks(3);
    rd(1'b0, v); chk(11, v, 32'd7, "resume after control write");

    // R4 / R10 sticky pending and software clear
    wr(1'b0, 32'd0);
    wr(1'b1, 32'hE000_0002);
    ticks(2);
    ticks(4);
    chk(4, {31'd0, irq_o}, 32'd1, "irq sticky");
    wr(1'b1, 32'hD000_0002);
    chk(4, {31'd0, irq_o}, 32'd0, "irq with enable off");
    rd(1'b1, v); chk(10, v, 32'hD000_0002, "pending kept");
    wr(1'b1, 32'hE000_0002);
    rd(1'b1, v); chk(10, v, 32'hE000_0002, "pending cleared by write");
    chk(4, {31'd0, irq_o}, 32'd0, "irq after clear");

    // R8 reset mid-run
    ticks(2);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    chk(8, {31'd0, irq_o}, 32'd0, "irq after second reset");
    rd(1'b0, v); chk(8, v, 32'd0, "count after second reset");
    rd(1'b1, v); chk(8, v, 32'd0, "control after second reset");

    done = 1'b1;
    finish_run();
  end
endmodule